// File: doc/BRIEF.md
# Serial Audio Capture Frame Buffer

This block receives a two-channel serial audio stream and gathers it into frames for a downstream transform engine. A bit clock times each data bit and a word clock selects the channel. Each channel slot yields one 16-bit sample, shifted in most significant bit first. A left sample and the right sample that follows it are packed into one 32-bit word: left in the upper half, which becomes the real part, and right in the lower half, which becomes the imaginary part. Each packed word is written into a frame memory.

When the memory holds a full frame, the block waits for the downstream engine to raise its transfer enable. It then streams the frame out as real/imaginary pairs with a valid strobe. The consumer can stall the stream with a hold input. Audio keeps arriving while the frame waits and while it streams out. Those pairs go into a small side buffer. Once the transfer ends, the side buffer is copied into the start of the memory, so the next frame continues the stream without a gap. If the side buffer fills, further arrivals are dropped and a sticky error flag is raised.

The serial inputs are sampled in the system clock domain, which must run at least twice as fast as the bit clock.

Top module: `audio_frame_capture`

## Requirements
- R1: After reset, out_vld, xfer_done and buf_ovf are low.
- R2: Serial bits are taken on rising edges of bit_clk, most significant bit first. A sample is the first 16 bits after word_clk changes level. word_clk low marks the left channel and high marks the right channel. A pair is formed when a right sample completes after a left sample. The left sample appears on out_real and the right sample on out_imag.
- R3: Bits after the 16th in a channel slot have no effect on the captured sample.
- R4: Once FRAME_PAIRS pairs are stored, no word is presented (out_vld stays low) until xfer_en is high.
- R5: During a transfer, the frame's pairs are presented in arrival order. A word is taken on a clock edge where out_vld is high and xfer_hold is low, and the next word is presented in the following cycle.
- R6: While out_vld and xfer_hold are both high, out_vld, out_real and out_imag keep their values.
- R7: xfer_done is high for exactly one cycle, the cycle after the last word of a frame is taken. out_vld is low in that cycle.
- R8: Pairs that arrive after a frame is full, whether during the wait for xfer_en or during the transfer, are kept. They become the first pairs of the next frame, in order.
- R9: The side buffer holds BUF_DEPTH pairs. A pair that arrives while it is full is dropped, and buf_ovf rises and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bit_clk | input | 1 | Serial bit clock |
| word_clk | input | 1 | Channel select clock: low is left, high is right |
| ser_data | input | 1 | Serial sample data, most significant bit first |
| xfer_en | input | 1 | Downstream engine ready to accept a full frame |
| xfer_hold | input | 1 | Stall of the frame stream |
| out_real | output | 16 | Left sample of the presented pair |
| out_imag | output | 16 | Right sample of the presented pair |
| out_vld | output | 1 | A pair is presented on out_real/out_imag |
| xfer_done | output | 1 | One-cycle pulse at the end of a frame transfer |
| buf_ovf | output | 1 | Sticky side-buffer overflow flag |

## Verification
The hardest situation to reach is a pair arriving while the memory is being streamed out. Each serial pair takes over a hundred system cycles, and a transfer lasts only a few cycles. The stimulus therefore stalls the first presented word with xfer_hold, shifts a whole pair in during the stall, and only then releases the stream. A second hard case is overflow, which needs the side buffer full while a frame waits. It is reached by keeping xfer_en low after a frame fills, sending BUF_DEPTH plus one pairs, and checking that the following frame skips exactly the dropped pair.

// File: rtl/afc_pkg.sv
package afc_pkg;
  // Controller phases
  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,   // pairs written straight into the frame memory
    ST_PEND  = 2'd1,   // frame full, waiting for the consumer; arrivals buffered
    ST_FLUSH = 2'd2,   // frame streamed out; arrivals buffered
    ST_EMPTY = 2'd3    // side buffer copied into the head of the memory
  } afc_state_e;
endpackage

// File: rtl/afc_bit_shifter.sv
module afc_bit_shifter #(
  parameter int SAMPLE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_clk,
  input  logic                  word_clk,
  input  logic                  ser_data,
  output logic                  pair_vld,
  output logic [2*SAMPLE_W-1:0] pair_word
);
  localparam int              BC_W     = $clog2(SAMPLE_W + 1);
  localparam logic [BC_W-1:0] CNT_FULL = BC_W'(SAMPLE_W);
  localparam logic [BC_W-1:0] CNT_LAST = BC_W'(SAMPLE_W - 1);
  localparam logic [BC_W-1:0] CNT_ONE  = BC_W'(1);

  logic                  bclk_q, slot_q, slot_n;
  logic [BC_W-1:0]       cnt_q, cnt_n;
  logic [SAMPLE_W-1:0]   sh_q, sh_n, sh_next;
  logic [SAMPLE_W-1:0]   left_q, left_n;
  logic                  have_q, have_n;
  logic                  pv_q, pv_n;
  logic [2*SAMPLE_W-1:0] pair_q, pair_n;
  logic                  rise, slot_edge, word_done;

  always_comb begin
    rise      = bit_clk & ~bclk_q;
    slot_edge = word_clk ^ slot_q;
    sh_next   = {sh_q[SAMPLE_W-2:0], ser_data};
    word_done = rise && !slot_edge && (cnt_q == CNT_LAST);
    slot_n = slot_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    left_n = left_q;
    have_n = have_q;
    pv_n   = 1'b0;
    pair_n = pair_q;
    if (rise) begin
      slot_n = word_clk;
      if (slot_edge) begin
        cnt_n = CNT_ONE;
        sh_n  = sh_next;
      end else if (cnt_q != CNT_FULL) begin
        cnt_n = cnt_q + CNT_ONE;
        sh_n  = sh_next;
      end
    end
    if (word_done) begin
      if (word_clk) begin
        if (have_q) begin
          pv_n   = 1'b1;
          pair_n = {left_q, sh_next};
        end
        have_n = 1'b0;
      end else begin
        left_n = sh_next;
        have_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      slot_q <= 1'b1;
      cnt_q  <= CNT_FULL;
      sh_q   <= '0;
      left_q <= '0;
      have_q <= 1'b0;
      pv_q   <= 1'b0;
      pair_q <= '0;
    end else begin
      bclk_q <= bit_clk;
      slot_q <= slot_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      left_q <= left_n;
      have_q <= have_n;
      pv_q   <= pv_n;
      pair_q <= pair_n;
    end
  end

  assign pair_vld  = pv_q;
  assign pair_word = pair_q;
endmodule

// File: rtl/afc_side_fifo.sv
module afc_side_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [WIDTH-1:0]               wdata,
  input  logic                           pop,
  output logic [WIDTH-1:0]               rdata,
  output logic                           empty,
  output logic                           full,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int             PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int             CNT_W   = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             do_push, do_pop;

  always_comb begin
    do_push = push && (cnt_q != CNT_MAX);
    do_pop  = pop && (cnt_q != '0);
    wp_n    = wp_q;
    rp_n    = rp_q;
    cnt_n   = cnt_q;
    if (do_push) wp_n = (wp_q == PTR_END) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_n = (rp_q == PTR_END) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop)      cnt_n = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store[wp_q] <= wdata;
  end

  assign rdata = store[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_MAX);
  assign count = cnt_q;
endmodule

// File: rtl/afc_ctrl.sv
module afc_ctrl
  import afc_pkg::*;
#(
  parameter int FRAME_PAIRS = 256
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           pair_vld,
  input  logic                           xfer_en,
  input  logic                           xfer_hold,
  input  logic                           fifo_empty,
  input  logic                           fifo_full,
  output afc_state_e                     state,
  output logic                           fifo_push,
  output logic                           fifo_pop,
  output logic                           mem_we,
  output logic                           mem_from_fifo,
  output logic [$clog2(FRAME_PAIRS)-1:0] wr_addr,
  output logic                           rd_fire,
  output logic [$clog2(FRAME_PAIRS)-1:0] rd_addr,
  output logic                           out_vld,
  output logic                           xfer_done,
  output logic                           buf_ovf
);
  localparam int               ADDR_W = $clog2(FRAME_PAIRS);
  localparam int               CNT_W  = ADDR_W + 1;
  localparam logic [CNT_W-1:0] N_ALL  = CNT_W'(FRAME_PAIRS);
  localparam logic [CNT_W-1:0] N_LAST = CNT_W'(FRAME_PAIRS - 1);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  afc_state_e       state_q, state_n;
  logic [CNT_W-1:0] wr_q, wr_n, rd_q, rd_n;
  logic             vld_q, vld_n, done_q, done_n, err_q, err_n;
  logic             load_ok;

  always_comb begin
    load_ok       = !vld_q || !xfer_hold;
    state_n       = state_q;
    wr_n          = wr_q;
    rd_n          = rd_q;
    vld_n         = vld_q;
    done_n        = 1'b0;
    fifo_push     = 1'b0;
    fifo_pop      = 1'b0;
    mem_we        = 1'b0;
    mem_from_fifo = 1'b0;
    rd_fire       = 1'b0;
    unique case (state_q)
      ST_FILL: begin
        if (pair_vld) begin
          mem_we = 1'b1;
          wr_n   = wr_q + ONE;
          if (wr_q == N_LAST) state_n = ST_PEND;
        end
      end
      ST_PEND: begin
        fifo_push = pair_vld;
        if (xfer_en) begin
          state_n = ST_FLUSH;
          rd_n    = '0;
        end
      end
      ST_FLUSH: begin
        fifo_push = pair_vld;
        if (load_ok) begin
          if (rd_q != N_ALL) begin
            rd_fire = 1'b1;
            rd_n    = rd_q + ONE;
            vld_n   = 1'b1;
          end else begin
            vld_n   = 1'b0;
            done_n  = 1'b1;
            wr_n    = '0;
            state_n = ST_EMPTY;
          end
        end
      end
      ST_EMPTY: begin
        fifo_push = pair_vld;
        if (!fifo_empty) begin
          fifo_pop      = 1'b1;
          mem_we        = 1'b1;
          mem_from_fifo = 1'b1;
          wr_n          = wr_q + ONE;
        end else if (!pair_vld) begin
          state_n = ST_FILL;
        end
      end
      default: state_n = ST_FILL;
    endcase
    err_n = err_q | (fifo_push & fifo_full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FILL;
      wr_q    <= '0;
      rd_q    <= '0;
      vld_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      wr_q    <= wr_n;
      rd_q    <= rd_n;
      vld_q   <= vld_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  assign state     = state_q;
  assign wr_addr   = wr_q[ADDR_W-1:0];
  assign rd_addr   = rd_q[ADDR_W-1:0];
  assign out_vld   = vld_q;
  assign xfer_done = done_q;
  assign buf_ovf   = err_q;
endmodule

// File: rtl/audio_frame_capture.sv
module audio_frame_capture
  import afc_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int FRAME_PAIRS = 256,
  parameter int BUF_DEPTH   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_clk,
  input  logic                word_clk,
  input  logic                ser_data,
  input  logic                xfer_en,
  input  logic                xfer_hold,
  output logic [SAMPLE_W-1:0] out_real,
  output logic [SAMPLE_W-1:0] out_imag,
  output logic                out_vld,
  output logic                xfer_done,
  output logic                buf_ovf
);
  localparam int WORD_W = 2 * SAMPLE_W;
  localparam int ADDR_W = $clog2(FRAME_PAIRS);
  localparam int FCNT_W = $clog2(BUF_DEPTH + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic              pair_vld;
  logic [WORD_W-1:0] pair_word;
  logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [WORD_W-1:0] fifo_rdata;
  logic [FCNT_W-1:0] fifo_count;
  afc_state_e        ctl_state;
  logic              mem_we, mem_from_fifo, rd_fire;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [WORD_W-1:0] mem_wdata, out_word;
  logic [WORD_W-1:0] frame_mem [FRAME_PAIRS];

  afc_bit_shifter #(.SAMPLE_W(SAMPLE_W)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bit_clk  (bit_clk),
    .word_clk (word_clk),
    .ser_data (ser_data),
    .pair_vld (pair_vld),
    .pair_word(pair_word)
  );

  afc_side_fifo #(.WIDTH(WORD_W), .DEPTH(BUF_DEPTH)) u_side_fifo (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .push (fifo_push),
    .wdata(pair_word),
    .pop  (fifo_pop),
    .rdata(fifo_rdata),
    .empty(fifo_empty),
    .full (fifo_full),
    .count(fifo_count)
  );

  afc_ctrl #(.FRAME_PAIRS(FRAME_PAIRS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .pair_vld     (pair_vld),
    .xfer_en      (xfer_en),
    .xfer_hold    (xfer_hold),
    .fifo_empty   (fifo_empty),
    .fifo_full    (fifo_full),
    .state        (ctl_state),
    .fifo_push    (fifo_push),
    .fifo_pop     (fifo_pop),
    .mem_we       (mem_we),
    .mem_from_fifo(mem_from_fifo),
    .wr_addr      (wr_addr),
    .rd_fire      (rd_fire),
    .rd_addr      (rd_addr),
    .out_vld      (out_vld),
    .xfer_done    (xfer_done),
    .buf_ovf      (buf_ovf)
  );

  assign mem_wdata = mem_from_fifo ? fifo_rdata : pair_word;

  always_ff @(posedge clk) begin
    if (mem_we) frame_mem[wr_addr] <= mem_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_word <= '0;
    else if (rd_fire) out_word <= frame_mem[rd_addr];
  end

  assign out_real = out_word[WORD_W-1 -: SAMPLE_W];
  assign out_imag = out_word[SAMPLE_W-1:0];
endmodule

// File: rtl/audio_frame_capture_chk.sv
module audio_frame_capture_chk
  import afc_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int BUF_DEPTH = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input afc_state_e                   state,
  input logic                         fifo_empty,
  input logic [$clog2(BUF_DEPTH+1)-1:0] fifo_count,
  input logic                         xfer_hold,
  input logic [SAMPLE_W-1:0]          out_real,
  input logic [SAMPLE_W-1:0]          out_imag,
  input logic                         out_vld,
  input logic                         xfer_done,
  input logic                         buf_ovf
);
  localparam int                 FCNT_W  = $clog2(BUF_DEPTH + 1);
  localparam logic [FCNT_W-1:0]  FCNT_MX = FCNT_W'(BUF_DEPTH);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  a_r7_done_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> ($past(out_vld) && !out_vld));

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && xfer_hold) |=> (out_vld && $stable(out_real) && $stable(out_imag)));

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ovf |=> buf_ovf);

  a_r9_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= FCNT_MX);

  a_r8_buffer_drained_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL) |-> fifo_empty);

  a_r5_valid_only_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (state == ST_FLUSH));
endmodule

bind audio_frame_capture audio_frame_capture_chk #(
  .SAMPLE_W (SAMPLE_W),
  .BUF_DEPTH(BUF_DEPTH)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .state     (ctl_state),
  .fifo_empty(fifo_empty),
  .fifo_count(fifo_count),
  .xfer_hold (xfer_hold),
  .out_real  (out_real),
  .out_imag  (out_imag),
  .out_vld   (out_vld),
  .xfer_done (xfer_done),
  .buf_ovf   (buf_ovf)
);

// File: tb/test_audio_frame_capture.sv
module test_audio_frame_capture;
  localparam int FP = 8;
  localparam int BD = 4;

  typedef struct packed {
    logic [15:0] l;
    logic [15:0] r;
    logic [3:0]  extra;  // surplus bits appended to the left slot
  } vec_t;

  localparam vec_t VEC [FP] = '{
    '{16'h0000, 16'hFFFF, 4'd0},
    '{16'hFFFF, 16'h0000, 4'd0},
    '{16'h8000, 16'h0001, 4'd0},
    '{16'h0001, 16'h8000, 4'd4},
    '{16'hA5C3, 16'h3C5A, 4'd0},
    '{16'h1234, 16'hFEDC, 4'd7},
    '{16'h7FFF, 16'h8001, 4'd0},
    '{16'h5555, 16'hAAAA, 4'd2}
  };

  logic        clk, rst_n, bit_clk, word_clk, ser_data, xfer_en, xfer_hold;
  logic [15:0] out_real, out_imag;
  logic        out_vld, xfer_done, buf_ovf;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] exp_q [$];

  audio_frame_capture #(.SAMPLE_W(16), .FRAME_PAIRS(FP), .BUF_DEPTH(BD)) i_audio_frame_capture (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .word_clk(word_clk), .ser_data(ser_data),
    .xfer_en(xfer_en), .xfer_hold(xfer_hold), .out_real(out_real), .out_imag(out_imag),
    .out_vld(out_vld), .xfer_done(xfer_done), .buf_ovf(buf_ovf)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int n);
    logic [15:0] a, b;
    a = 16'(n * 4919 + 3855);
    b = 16'(~(n * 9320));
    return {a, b};
  endfunction

  task automatic send_bit(input logic b);
    ser_data = b;
    bit_clk  = 1'b0;
    repeat (2) @(negedge clk);
    bit_clk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_slot(input logic lr, input logic [15:0] w, input int extra);
    word_clk = lr;
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
    for (int i = 0; i < extra; i++) send_bit(~w[0]);
    bit_clk = 1'b0;
  endtask

  task automatic send_pair(input logic [31:0] p, input int extra, input bit keep);
    send_slot(1'b0, p[31:16], extra);
    send_slot(1'b1, p[15:0], 0);
    repeat (4) @(negedge clk);
    if (keep) exp_q.push_back(p);
  endtask

  // mode 0: no stall, 1: periodic stall, 2: long stall with a pair arriving
  task automatic flush_frame(input int mode, input string tag);
    int          taken = 0;
    int          guard = 0;
    bit          held = 0;
    bit          did_long = 0;
    bit          early_done = 0;
    logic        h;
    logic [31:0] snap, e;
    @(negedge clk);
    xfer_en = 1'b1;
    while (taken < FP && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (out_vld) xfer_en = 1'b0;
      if (xfer_done) early_done = 1;
      if (held) chk("R6 stalled word", {out_vld, out_real, out_imag}, {1'b1, snap});
      h = (mode == 1) ? ((guard % 3) == 1) : 1'b0;
      if (mode == 2 && out_vld && !did_long) begin
        did_long  = 1;
        snap      = {out_real, out_imag};
        xfer_hold = 1'b1;
        send_pair(pat(300), 0, 1);
        chk("R6 R8 stall during arrival", {out_vld, out_real, out_imag}, {1'b1, snap});
      end
      xfer_hold = h;
      held = out_vld && h;
      if (held) snap = {out_real, out_imag};
      if (out_vld && !h) begin
        e = exp_q.pop_front();
        chk(tag, {1'b0, out_real, out_imag}, {1'b0, e});
        taken++;
      end
    end
    xfer_hold = 1'b0;
    xfer_en   = 1'b0;
    chk("R5 all words taken", 33'(taken), 33'(FP));
    chk("R7 no early done", 33'(early_done), 33'd0);
    @(negedge clk);
    chk("R7 done high after last word", 33'(xfer_done), 33'd1);
    chk("R7 valid low with done", 33'(out_vld), 33'd0);
    @(negedge clk);
    chk("R7 done single cycle", 33'(xfer_done), 33'd0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    bit any_vld;
    rst_n = 1'b0; bit_clk = 1'b0; word_clk = 1'b1; ser_data = 1'b0;
    xfer_en = 1'b0; xfer_hold = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 reset outputs", {30'd0, out_vld, xfer_done, buf_ovf}, 33'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 outputs after release", {30'd0, out_vld, xfer_done, buf_ovf}, 33'd0);

    // frame 1: table-driven, some left slots carry surplus bits (R3)
    for (int i = 0; i < FP; i++) send_pair({VEC[i].l, VEC[i].r}, int'(VEC[i].extra), 1);
    send_pair(pat(100), 0, 1);
    send_pair(pat(101), 0, 1);
    any_vld = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (out_vld) any_vld = 1;
    end
    chk("R4 no output before enable", 33'(any_vld), 33'd0);
    flush_frame(1, "R2 R3 R5 data order");

    // frame 2: starts with the two waiting pairs (R8), long stall mid-transfer
    for (int i = 0; i < FP - 2; i++) send_pair(pat(200 + i), 0, 1);
    flush_frame(2, "R8 buffered pairs lead next frame");

    // frame 3: one pair arrived during the transfer, then overflow (R9)
    for (int i = 0; i < FP - 1; i++) send_pair(pat(400 + i), 0, 1);
    chk("R9 flag low before overflow", 33'(buf_ovf), 33'd0);
    for (int i = 0; i < BD; i++) send_pair(pat(500 + i), 0, 1);
    chk("R9 flag low at exactly full", 33'(buf_ovf), 33'd0);
    send_pair(pat(600), 0, 0);
    chk("R9 overflow flag set", 33'(buf_ovf), 33'd1);
    flush_frame(0, "R5 frame after overflow");

    // frame 4: the dropped pair must be absent
    for (int i = 0; i < FP - BD; i++) send_pair(pat(700 + i), 0, 1);
    flush_frame(0, "R9 dropped pair excluded");
    chk("R9 flag sticky", 33'(buf_ovf), 33'd1);

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset clears flag", {30'd0, out_vld, xfer_done, buf_ovf}, 33'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule